// File: doc/BRIEF.md
# Stream identifier span match filter

This block decides whether an incoming event belongs to a programmed stream selection. Each event carries a stream identifier together with a one-cycle valid strobe. The block compares that identifier against a filter value. In exact mode every bit must agree. In span mode a run of low bits is ignored.

The ignored run is encoded inside the filter value and not held in a mask register of its own. Counting from bit 0, the filter value holds a run of ones, and the first zero ends the run. That zero and every one below it are don't-care positions. All bits above the zero must equal the identifier. A filter of all ones in span mode therefore passes every identifier. This is the setting a counter uses when no filtering is wanted.

The decision is registered. One cycle after a valid event, a qualified pulse appears that can drive a counter's increment directly. A held flag also keeps the result of the most recent event.

Top module: `sidf_span_filter`

## Requirements
- R1: While `rst_n` is low at a clock edge, both `hit_pulse` and `match_q` are 0 after that edge.
- R2: With `flt_span` = 0, an event passes only if `evt_id` equals `flt_value` on every bit.
- R3: With `flt_span` = 1, let Y-1 be the position of the lowest 0 bit of `flt_value` (all bits below it are 1). Bits 0 to Y-1 of the identifier are ignored, and bits Y and up must equal `flt_value`. For a value of 0x7FFFFFFF nothing is compared.
- R4: With `flt_span` = 1 and `flt_value` = 0x42, identifiers 0x42 and 0x43 pass, and 0x40, 0x41 and 0x44 fail.
- R5: With `flt_span` = 1 and `flt_value` = 0xFFFFFFFF, every identifier passes.
- R6: With `flt_span` = 1 and `flt_value` = 0x0000FFFF, bits 0 to 16 are ignored: 0x00012345 passes and 0x00020000 fails.
- R7: `hit_pulse` is high in the cycle after a cycle with `evt_valid` = 1 and a passing identifier, and is low in every other cycle. Back-to-back events each give their own result.
- R8: `match_q` takes the pass result of each valid event one cycle later. It holds its value through cycles with `evt_valid` = 0, whatever `evt_id` and the filter inputs do.
- R9: With `flt_span` = 0 and `flt_value` = 0xFFFFFFFF, only the identifier 0xFFFFFFFF passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flt_value | input | ID_W | Filter value; in span mode it also encodes the ignored low run |
| flt_span | input | 1 | 1 = span match, 0 = exact match |
| evt_id | input | ID_W | Stream identifier of the current event |
| evt_valid | input | 1 | Event present this cycle |
| hit_pulse | output | 1 | Qualified event pulse, one cycle after a passing event |
| match_q | output | 1 | Pass result of the most recent valid event, held between events |

## Verification
Two things can happen in the same cycle: a new event is being compared while the previous event's result is being registered, and the filter value or mode may change. The bench holds `evt_valid` high through the whole vector table and changes filter, mode and identifier every cycle. Each result is judged at the falling edge after its event, before the next event's outcome can overwrite the registers. This shows that each pulse reflects only the filter present in its own event's cycle.

// File: rtl/sidf_pkg.sv
// Package: shared choices for the stream identifier span filter.
// Assumes: nothing; holds only types.
package sidf_pkg;
    // How the ignore mask is derived from the filter value.
    typedef enum logic {
        MASK_ADDER = 1'b0,  // value XOR (value + 1)
        MASK_CHAIN = 1'b1   // running AND of the low bits
    } mask_style_e;
endpackage

// File: rtl/sidf_mask_decode.sv
// Module: sidf_mask_decode
// Turns the filter value into a don't-care mask. In span mode the mask
// covers the trailing run of ones plus the first zero above it; in exact
// mode it is zero. Two equivalent structures are selectable.
// Assumes: ID_W >= 2; purely combinational.
module sidf_mask_decode #(
    parameter int                    ID_W  = 32,
    parameter sidf_pkg::mask_style_e STYLE = sidf_pkg::MASK_CHAIN
) (
    input  logic [ID_W-1:0] value,
    input  logic            span,
    output logic [ID_W-1:0] ignore_mask
);
    localparam logic [ID_W-1:0] ONE = {{(ID_W-1){1'b0}}, 1'b1};

    logic [ID_W-1:0] run_mask;

    generate
        if (STYLE == sidf_pkg::MASK_CHAIN) begin : g_chain
            // bit i is don't-care when every bit below it is one
            assign run_mask[0] = 1'b1;
            for (genvar i = 1; i < ID_W; i++) begin : g_bit
                assign run_mask[i] = run_mask[i-1] & value[i-1];
            end
        end else begin : g_adder
            // the carry of value+1 flips exactly the trailing run and its end
            assign run_mask = value ^ (value + ONE);
        end
    endgenerate

    // exact mode ignores nothing
    always_comb begin
        ignore_mask = span ? run_mask : '0;
    end
endmodule

// File: rtl/sidf_compare.sv
// Module: sidf_compare
// Compares the event identifier with the filter value on every bit the
// mask does not cover.
// Assumes: purely combinational; mask already qualified by mode.
module sidf_compare #(
    parameter int ID_W = 32
) (
    input  logic [ID_W-1:0] id,
    input  logic [ID_W-1:0] value,
    input  logic [ID_W-1:0] ignore_mask,
    output logic            pass
);
    logic [ID_W-1:0] diff;

    // differing bits that are still compared
    always_comb begin
        diff = (id ^ value) & ~ignore_mask;
        pass = ~|diff;
    end
endmodule

// File: rtl/sidf_hit_reg.sv
// Module: sidf_hit_reg
// Registers the pass decision: a one-cycle qualified pulse per valid event
// and a flag that holds the most recent event's result.
// Assumes: synchronous active-low reset.
module sidf_hit_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic valid,
    input  logic pass,
    output logic hit_pulse,
    output logic match_q
);
    // pulse tracks valid-and-pass every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) hit_pulse <= 1'b0;
        else        hit_pulse <= valid & pass;
    end

    // held flag updates only when an event is present
    always_ff @(posedge clk) begin
        if (!rst_n)     match_q <= 1'b0;
        else if (valid) match_q <= pass;
    end
endmodule

// File: rtl/sidf_span_filter.sv
// Module: sidf_span_filter (top)
// Stream identifier filter with exact and span modes; the span's ignored
// low run is encoded in the filter value itself. Result registered once.
// Assumes: filter inputs are stable during the cycle of the event they
// apply to; synchronous active-low reset.
module sidf_span_filter #(
    parameter int                    ID_W       = 32,
    parameter sidf_pkg::mask_style_e MASK_STYLE = sidf_pkg::MASK_CHAIN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ID_W-1:0] flt_value,
    input  logic            flt_span,
    input  logic [ID_W-1:0] evt_id,
    input  logic            evt_valid,
    output logic            hit_pulse,
    output logic            match_q
);
    localparam logic [ID_W-1:0] ONE = {{(ID_W-1){1'b0}}, 1'b1};

    logic [ID_W-1:0] ignore_mask;
    logic            pass;

    sidf_mask_decode #(.ID_W(ID_W), .STYLE(MASK_STYLE)) u_mask (
        .value       (flt_value),
        .span        (flt_span),
        .ignore_mask (ignore_mask)
    );

    sidf_compare #(.ID_W(ID_W)) u_cmp (
        .id          (evt_id),
        .value       (flt_value),
        .ignore_mask (ignore_mask),
        .pass        (pass)
    );

    sidf_hit_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (evt_valid),
        .pass      (pass),
        .hit_pulse (hit_pulse),
        .match_q   (match_q)
    );

    // R3: span mask is a nonempty contiguous run starting at bit 0
    a_r3_mask_low_run: assert property (@(posedge clk) disable iff (!rst_n)
        flt_span |-> (ignore_mask[0] && ((ignore_mask & (ignore_mask + ONE)) == '0)));

    // R2: exact mode ignores no bit
    a_r2_exact_no_mask: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_span |-> (ignore_mask == '0));

    // R2: exact mismatch never yields a pulse
    a_r2_exact_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !flt_span && (evt_id != flt_value)) |=> !hit_pulse);

    // R5: all-ones span filter passes anything
    a_r5_all_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && flt_span && (&flt_value)) |=> hit_pulse);

    // R7: no pulse without an event the cycle before
    a_r7_no_pulse_without_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_valid |=> !hit_pulse);

    // R8: held flag is stable across idle cycles
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_valid |=> $stable(match_q));
endmodule

// File: tb/sim_sidf_span_filter.sv
module sim_sidf_span_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] flt_value = '0;
    logic        flt_span = 1'b0;
    logic [31:0] evt_id = '0;
    logic        evt_valid = 1'b0;
    logic        hit_pulse;
    logic        match_q;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk; // 250 MHz

    sidf_span_filter u0 (
        .clk(clk), .rst_n(rst_n), .flt_value(flt_value), .flt_span(flt_span),
        .evt_id(evt_id), .evt_valid(evt_valid),
        .hit_pulse(hit_pulse), .match_q(match_q)
    );

    typedef struct packed {
        logic [31:0] val;
        logic        span;
        logic [31:0] id;
        logic        exp;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1234, 1'b0, 32'h0000_1234, 1'b1}, // R2 equal
        '{32'h0000_1234, 1'b0, 32'h0000_1235, 1'b0}, // R2 low bit differs
        '{32'h8000_0000, 1'b0, 32'h0000_0000, 1'b0}, // R2 top bit differs
        '{32'h0000_0042, 1'b1, 32'h0000_0042, 1'b1}, // R4
        '{32'h0000_0042, 1'b1, 32'h0000_0043, 1'b1}, // R4
        '{32'h0000_0042, 1'b1, 32'h0000_0040, 1'b0}, // R4
        '{32'h0000_0042, 1'b1, 32'h0000_0044, 1'b0}, // R4
        '{32'h0000_0042, 1'b1, 32'h1000_0042, 1'b0}, // R3 high bit compared
        '{32'h0000_FFFF, 1'b1, 32'h0001_2345, 1'b1}, // R6
        '{32'h0000_FFFF, 1'b1, 32'h0002_0000, 1'b0}, // R6
        '{32'h0000_0137, 1'b1, 32'h0000_013A, 1'b1}, // R3 low 4 ignored
        '{32'h0000_0137, 1'b1, 32'h0000_014A, 1'b0}, // R3 bit 6 compared
        '{32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 1'b1}, // R5
        '{32'hFFFF_FFFF, 1'b1, 32'hDEAD_BEEF, 1'b1}, // R5
        '{32'hFFFF_FFFF, 1'b0, 32'hFFFF_FFFE, 1'b0}, // R9
        '{32'hFFFF_FFFF, 1'b0, 32'hFFFF_FFFF, 1'b1}, // R9
        '{32'h7FFF_FFFF, 1'b1, 32'h0000_0001, 1'b1}  // R3 nothing compared
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hung expected done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 hit_pulse reset", hit_pulse, 1'b0);
        check("R1 match_q reset", match_q, 1'b0);
        rst_n = 1'b1;

        // back-to-back table walk: check previous, apply next (R7 per event)
        for (int i = 0; i <= NV; i++) begin
            @(negedge clk);
            if (i > 0) begin
                check($sformatf("R7 pulse vec %0d", i-1), hit_pulse, VECS[i-1].exp);
                check($sformatf("R8 flag vec %0d", i-1), match_q, VECS[i-1].exp);
            end
            if (i < NV) begin
                flt_value = VECS[i].val;
                flt_span  = VECS[i].span;
                evt_id    = VECS[i].id;
                evt_valid = 1'b1;
            end else begin
                evt_valid = 1'b0;
            end
        end
        // last table entry passed, so match_q is 1 here
        // R8: idle with a mismatching id must not disturb the flag
        flt_span  = 1'b0;
        flt_value = 32'h0000_0001;
        evt_id    = 32'h0000_0002;
        @(negedge clk);
        check("R7 no pulse when idle", hit_pulse, 1'b0);
        check("R8 flag held idle", match_q, 1'b1);
        @(negedge clk);
        check("R8 flag still held", match_q, 1'b1);

        // R8: a failing event clears the flag, no pulse
        evt_valid = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0;
        check("R8 flag cleared by miss", match_q, 1'b0);
        check("R2 miss gives no pulse", hit_pulse, 1'b0);

        // R7: single passing event gives exactly one pulse cycle
        evt_id    = 32'h0000_0001;
        evt_valid = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0;
        check("R7 single pulse high", hit_pulse, 1'b1);
        @(negedge clk);
        check("R7 single pulse ends", hit_pulse, 1'b0);
        check("R8 flag set", match_q, 1'b1);

        // R1: reset mid-run clears held flag
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 flag cleared by reset", match_q, 1'b0);
        check("R1 pulse cleared by reset", hit_pulse, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule